// File: doc/BRIEF.md
# Serial Audio Slot Transmitter

This block turns parallel audio samples into a time-division-multiplexed serial stream on one data line. A bit-clock enable, generated elsewhere, advances the output by one bit per pulse. A frame is a configurable number of slots, and each slot is a configurable number of bit periods. A single-entry holding register accepts samples from the write port. Its contents move into the shifter at the start of every slot. When the sample is shorter than the slot, the alignment and padding settings decide what fills the spare bit periods.

A one-bit frame sync marks each frame, either together with the first bit of slot 0 or one bit period earlier. A section-local soft reset silences the outputs at once and returns the status flags to their power-on values. It leaves the configuration inputs alone. An empty flag, an underrun flag and a gated exception interrupt report how the sample supply is keeping up.

Top module: `tdm_slot_tx`

## Requirements
- R1: After rst_n is asserted: sd_oe=0, fsync=0, tx_empty=1, tx_underrun=0, tx_irq=0.
- R2: Serial order and timing:
  - Each bclk_en pulse advances one bit period, and outputs update on that clock edge.
  - Transmission starts at slot 0, bit 0 on the first pulse after any reset.
  - A sample's word is wr_data[word_len-1:0], and it is sent most significant bit first.
  - A slot lasts slot_len bit periods, and a frame lasts num_slots slots.
  - When word_len equals slot_len, the slot carries exactly the word.
- R3: With fs_early=0, fsync is 1 only during bit 0 of slot 0.
- R4: With fs_early=1, fsync is 1 only during the last bit of the last slot of each frame. No early sync precedes the first frame after a start.
- R5: With right_align=0 and zero_pad=0, the word fills the first word_len bit periods, and word bit 0 is repeated in the remaining bit periods.
- R6: With right_align=0 and zero_pad=1, zeros fill the bit periods after the word.
- R7: With right_align=1 and zero_pad=0, the word's most significant bit is repeated in the leading slot_len-word_len bit periods, and the word follows.
- R8: With right_align=1 and zero_pad=1, zeros fill the leading bit periods before the word.
- R9: A write clears tx_empty. The start of a slot takes the held sample and sets tx_empty.
- R10: If a slot starts while tx_empty=1, tx_underrun is set and the previous word is sent again.
- R11: tx_irq is 1 exactly when irq_en, tx_empty and tx_underrun are all 1.
- R12: tx_underrun clears only on a write that follows a status_rd pulse seen while tx_underrun was set. A write without that read leaves tx_underrun set.
- R13: While soft_rst is 1, the following hold in the same cycle:
  - sd_oe=0 and fsync=0;
  - tx_empty=1 and tx_underrun=0.

  After soft_rst is released, transmission restarts at slot 0, bit 0 with the configuration inputs as driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Transmitter section soft reset |
| bclk_en | input | 1 | One pulse per serial bit period |
| word_len | input | 5 | Data word length in bits |
| slot_len | input | 6 | Slot length in bit periods (at least word_len, at least 2) |
| num_slots | input | 4 | Slots per frame (at least 1) |
| fs_early | input | 1 | Frame sync one bit period early |
| right_align | input | 1 | Word sits at the end of the slot |
| zero_pad | input | 1 | Pad with zeros instead of repeating an edge bit |
| irq_en | input | 1 | Exception interrupt enable |
| wr_en | input | 1 | Sample write strobe |
| wr_data | input | 24 | Sample, right-justified |
| status_rd | input | 1 | Status read strobe |
| tx_empty | output | 1 | Holding register empty |
| tx_underrun | output | 1 | Underrun flag |
| tx_irq | output | 1 | Exception interrupt |
| sd_out | output | 1 | Serial data |
| sd_oe | output | 1 | Serial data output enable |
| fsync | output | 1 | Frame sync |

## Verification
A corrupted bit or slot counter shows on sd_out as a shifted or truncated word, and on fsync as a misplaced pulse. Both appear within the first slot that the bench records bit by bit. A wrong holding-register flag is visible on tx_empty in the cycle right after the write or the slot start. A missed underrun appears as a changed retransmitted word or a quiet tx_irq at the very next slot boundary. The soft-reset path is checked in the same cycle it is raised, before any clock edge.

// File: rtl/tdm_slot_tx.sv
module tdm_slot_tx #(
  parameter int MAXW = 24,
  parameter int MAXS = 32,
  parameter int MAXN = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          soft_rst,
  input  logic                          bclk_en,
  input  logic [$clog2(MAXW+1)-1:0]     word_len,
  input  logic [$clog2(MAXS+1)-1:0]     slot_len,
  input  logic [$clog2(MAXN+1)-1:0]     num_slots,
  input  logic                          fs_early,
  input  logic                          right_align,
  input  logic                          zero_pad,
  input  logic                          irq_en,
  input  logic                          wr_en,
  input  logic [MAXW-1:0]               wr_data,
  input  logic                          status_rd,
  output logic                          tx_empty,
  output logic                          tx_underrun,
  output logic                          tx_irq,
  output logic                          sd_out,
  output logic                          sd_oe,
  output logic                          fsync
);
  localparam int WLW = $clog2(MAXW+1);
  localparam int SLW = $clog2(MAXS+1);
  localparam int NW  = $clog2(MAXN+1);

  logic            active, full, urun, rd_seen;
  logic [SLW-1:0]  bit_q;
  logic [NW-1:0]   slot_q;
  logic [MAXW-1:0] word_q, hold_q;

  wire last_bit  = bit_q == slot_len - SLW'(1);
  wire last_slot = slot_q == num_slots - NW'(1);
  wire load      = bclk_en & (~active | last_bit);
  wire live      = active & ~soft_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; bit_q <= '0; slot_q <= '0;
      full <= 1'b0; urun <= 1'b0; rd_seen <= 1'b0;
      word_q <= '0; hold_q <= '0;
    end else if (soft_rst) begin
      active <= 1'b0; bit_q <= '0; slot_q <= '0;
      full <= 1'b0; urun <= 1'b0; rd_seen <= 1'b0;
    end else begin
      if (bclk_en) begin
        active <= 1'b1;
        if (!active) begin
          bit_q <= '0; slot_q <= '0;
        end else if (last_bit) begin
          bit_q  <= '0;
          slot_q <= last_slot ? '0 : slot_q + NW'(1);
        end else begin
          bit_q <= bit_q + SLW'(1);
        end
      end
      if (status_rd && urun) rd_seen <= 1'b1;
      if (wr_en) begin
        hold_q <= wr_data;
        rd_seen <= 1'b0;
        if (rd_seen) urun <= 1'b0;
      end
      if (load) begin
        if (full) word_q <= hold_q;
        else      urun   <= 1'b1;
      end
      full <= (full & ~load) | wr_en;
    end
  end

  logic [SLW-1:0]  sh, pad;
  logic [MAXW-1:0] shifted, msb_vec;
  logic            in_word, fill;

  always_comb begin
    pad     = slot_len - SLW'(word_len);
    msb_vec = word_q >> (word_len - WLW'(1));
    if (!right_align) begin
      in_word = bit_q < SLW'(word_len);
      sh      = SLW'(word_len) - SLW'(1) - bit_q;
      fill    = ~zero_pad & word_q[0];
    end else begin
      in_word = bit_q >= pad;
      sh      = slot_len - SLW'(1) - bit_q;
      fill    = ~zero_pad & msb_vec[0];
    end
    shifted = word_q >> sh;
  end

  assign sd_oe       = live;
  assign sd_out      = live & (in_word ? shifted[0] : fill);
  assign fsync       = live & (fs_early ? (last_slot & last_bit) : (slot_q == '0 && bit_q == '0));
  assign tx_empty    = ~full | soft_rst;
  assign tx_underrun = urun & ~soft_rst;
  assign tx_irq      = irq_en & tx_empty & tx_underrun;

  p_quiet_in_soft_reset_r13: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> !sd_oe && !fsync && tx_empty && !tx_underrun);
  p_fsync_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fsync && bclk_en && !soft_rst |=> !fsync);
  p_underrun_on_starve_r10: assert property (@(posedge clk) disable iff (!rst_n)
    active && bclk_en && last_bit && !full && !soft_rst |=> tx_underrun);
  p_irq_needs_flags_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> tx_underrun && tx_empty && irq_en);
  p_load_drains_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load && full && !wr_en && !soft_rst |=> tx_empty);
  p_write_fills_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !soft_rst |=> !tx_empty || soft_rst);
endmodule

// File: tb/test_tdm_slot_tx.sv
module test_tdm_slot_tx;
  logic clk = 0, rst_n = 0, soft_rst = 0, bclk_en = 0;
  logic [4:0] word_len = 5'd16;
  logic [5:0] slot_len = 6'd16;
  logic [3:0] num_slots = 4'd2;
  logic fs_early = 0, right_align = 0, zero_pad = 0, irq_en = 0;
  logic wr_en = 0, status_rd = 0;
  logic [23:0] wr_data = '0;
  logic tx_empty, tx_underrun, tx_irq, sd_out, sd_oe, fsync;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tdm_slot_tx i_tdm_slot_tx (.*);

  // W(5) S(6) N(4) early right zpad seed(24)
  localparam logic [41:0] VEC [6] = '{
    {5'd16, 6'd16, 4'd2, 1'b0, 1'b0, 1'b0, 24'h00B2C7},
    {5'd8,  6'd16, 4'd2, 1'b0, 1'b0, 1'b0, 24'h0000C5},
    {5'd8,  6'd16, 4'd3, 1'b1, 1'b0, 1'b1, 24'h0000B3},
    {5'd12, 6'd16, 4'd2, 1'b0, 1'b1, 1'b0, 24'h0009A5},
    {5'd12, 6'd20, 4'd3, 1'b1, 1'b1, 1'b1, 24'h000C3D},
    {5'd24, 6'd32, 4'd1, 1'b1, 1'b0, 1'b1, 24'hF0A55A}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk) bclk_en = 1;
    @(negedge clk) bclk_en = 0;
  endtask

  task automatic wr(input logic [23:0] d);
    @(negedge clk) begin wr_en = 1; wr_data = d; end
    @(negedge clk) wr_en = 0;
  endtask

  task automatic sreset();
    @(negedge clk) soft_rst = 1;
    @(negedge clk);
    @(negedge clk) soft_rst = 0;
  endtask

  function automatic logic ebit(input logic [23:0] w, input int W, input int S, input int b,
                                input logic ra, input logic zp);
    int pad = S - W;
    if (!ra) return (b < W) ? w[W-1-b] : (zp ? 1'b0 : w[0]);
    else     return (b < pad) ? (zp ? 1'b0 : w[W-1]) : w[S-1-b];
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!sd_oe && !fsync && tx_empty && !tx_underrun && !tx_irq, "R1 reset state",
        {sd_oe, fsync, tx_empty, tx_underrun, tx_irq}, 5'b00100);
    @(negedge clk) rst_n = 1;

    for (int v = 0; v < 6; v++) begin
      int W, S, N, dbad, fbad;
      logic [23:0] seed;
      logic [23:0] words [8];
      string dtag, ftag;
      W = VEC[v][41:37]; S = VEC[v][36:31]; N = VEC[v][30:27]; seed = VEC[v][23:0];
      @(negedge clk) soft_rst = 1;
      word_len = 5'(W); slot_len = 6'(S); num_slots = 4'(N);
      fs_early = VEC[v][26]; right_align = VEC[v][25]; zero_pad = VEC[v][24];
      @(negedge clk) soft_rst = 0;
      for (int s = 0; s < 8; s++) words[s] = (seed ^ 24'(s << 2)) & ((24'h1 << W) - 24'h1);
      if (W == 24) for (int s = 0; s < 8; s++) words[s] = seed ^ 24'(s << 2);
      if (W == S) dtag = "R2 full slot";
      else if (!right_align && !zero_pad) dtag = "R5 left repeat";
      else if (!right_align) dtag = "R6 left zeros";
      else if (!zero_pad) dtag = "R7 right repeat";
      else dtag = "R8 right zeros";
      ftag = fs_early ? "R4 early fsync" : "R3 coincident fsync";
      dbad = 0; fbad = 0;
      wr(words[0]);
      for (int s = 0; s < N; s++) begin
        for (int b = 0; b < S; b++) begin
          logic efs;
          step();
          efs = fs_early ? (s == N-1 && b == S-1) : (s == 0 && b == 0);
          if (!sd_oe || sd_out !== ebit(words[s], W, S, b, right_align, zero_pad)) dbad++;
          if (fsync !== efs) fbad++;
          if (b == 0 && s < N-1) wr(words[s+1]);
        end
      end
      chk(dbad == 0, dtag, dbad, 0);
      chk(fbad == 0, ftag, fbad, 0);
    end

    // Underrun, interrupt and clearing
    @(negedge clk) soft_rst = 1;
    word_len = 5'd8; slot_len = 6'd8; num_slots = 4'd1;
    fs_early = 0; right_align = 0; zero_pad = 0; irq_en = 1;
    @(negedge clk) soft_rst = 0;
    wr(24'hA5);
    chk(!tx_empty, "R9 write clears empty", tx_empty, 0);
    step();
    chk(tx_empty && !tx_underrun, "R9 slot start drains", {tx_empty, tx_underrun}, 2'b10);
    repeat (7) step();
    begin
      logic [7:0] got;
      step();
      got[7] = sd_out;
      chk(tx_underrun, "R10 underrun on empty slot", tx_underrun, 1);
      chk(tx_irq, "R11 irq when enabled", tx_irq, 1);
      for (int b = 6; b >= 0; b--) begin step(); got[b] = sd_out; end
      chk(got == 8'hA5, "R10 retransmit previous word", got, 8'hA5);
    end
    @(negedge clk) irq_en = 0;
    #1 chk(!tx_irq, "R11 irq masked", tx_irq, 0);
    @(negedge clk) irq_en = 1;
    wr(24'h3C);
    chk(tx_underrun && !tx_irq, "R12 write without read keeps underrun",
        {tx_underrun, tx_irq}, 2'b10);
    @(negedge clk) status_rd = 1;
    @(negedge clk) status_rd = 0;
    wr(24'h3C);
    chk(!tx_underrun, "R12 read then write clears", tx_underrun, 0);

    // Soft reset mid-slot
    repeat (9) step();
    chk(tx_underrun, "R10 underrun again", tx_underrun, 1);
    repeat (2) step();
    @(negedge clk) soft_rst = 1;
    #1 chk(!sd_oe && !fsync && !tx_underrun && tx_empty, "R13 immediate quiet",
           {sd_oe, fsync, tx_underrun, tx_empty}, 4'b0001);
    @(negedge clk);
    @(negedge clk) soft_rst = 0;
    chk(!sd_oe && tx_empty && !tx_underrun, "R13 flags after release",
        {sd_oe, tx_empty, tx_underrun}, 3'b010);
    wr(24'h81);
    step();
    chk(fsync && sd_oe && sd_out, "R13 restart at slot 0", {fsync, sd_oe, sd_out}, 3'b111);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule